// File: doc/BRIEF.md
# Continuous-Phase MSK Phase Modulator

The block turns a serial stream of binary symbols into the phase of a minimum-shift-keyed carrier. It also turns that phase into signed cosine and sine samples. One phase accumulator advances on every enabled sample clock. The amount it advances is a carrier step plus a deviation step for a 1 bit, or the carrier step minus the deviation step for a 0 bit. The deviation step is sized so that it adds exactly a quarter turn over one symbol of `SYM_LEN` samples. The accumulator is never reloaded, so the waveform has no phase jump where the data changes. The top bits of the phase address a quarter-wave sine table. That table drives registered constant-envelope I (cosine) and Q (sine) outputs.

A symbol source pulses `sym_stb` with the data bit once per symbol. The sample rate is set by `smp_en`. Neither the symbol input nor the sample output has back-pressure. The strobe is a plain control pin that is always accepted, and the output stream cannot be stalled. A consumer must take each sample in the single cycle that `out_vld` is high.

Top module: `msk_phase_mod`

## Requirements
- R1: After reset `phase_o` is 0, `out_vld` is 0, `cos_o` and `sin_o` are 0, and the current bit is 0. Before any strobe, an enabled sample therefore advances the phase by `CARR_INC - DEV_INC`.
- R2: Each cycle with `smp_en` high advances `phase_o` at the next clock edge. The advance is `CARR_INC + DEV_INC` when the current bit is 1 and `CARR_INC - DEV_INC` when it is 0, modulo 2^PW. A cycle with `smp_en` low leaves `phase_o` unchanged.
- R3: A cycle with `sym_stb` high makes `sym_bit` the current bit at that clock edge. A sample enabled in that same cycle still uses the previous bit. The new increment starts with the next enabled sample.
- R4: The phase is never reloaded at a symbol edge. Every change of `phase_o` between consecutive cycles is one of the two step values.
- R5: Over the `SYM_LEN` enabled samples that follow a strobe, `phase_o` changes by `CARR_INC*SYM_LEN + 2^(PW-2)` for bit 1 and by `CARR_INC*SYM_LEN - 2^(PW-2)` for bit 0, modulo 2^PW. These values hold whatever idle cycles fall between the samples.
- R6: `DEV_INC` equals 2^(PW-2)/SYM_LEN. The defaults (PW=16, SYM_LEN=16, CARR_INC=2048) make the carrier advance over one symbol a whole number of quarter turns, here two.
- R7: A sample enabled in cycle k is followed by `out_vld` high for exactly one cycle, in cycle k+2. `out_vld` is low two cycles after any cycle with `smp_en` low.
- R8: When `out_vld` is high, `cos_o` and `sin_o` equal round(A·cos θ) and round(A·sin θ) within 1 LSB. Here A = 2^(OW-1)-1. θ is the centre of the bucket selected by the top QA+2 bits of the phase that the sample produced, so bucket b has θ = (b+0.5)·2π/2^(QA+2). The top two phase bits give the quadrant, 0 to 3, counter-clockwise from 0.
- R9: When `out_vld` is high, cos_o² + sin_o² lies within A² ± (2A+2).
- R10: `cos_o` and `sin_o` hold their values in every cycle where no new sample is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | Sample enable; one phase advance per high cycle |
| sym_stb | input | 1 | Symbol strobe; loads `sym_bit` as the current bit |
| sym_bit | input | 1 | Data bit for the symbol that starts after the strobe |
| phase_o | output | PW | Accumulated carrier phase, unsigned fraction of a turn |
| cos_o | output | OW | Signed in-phase sample |
| sin_o | output | OW | Signed quadrature sample |
| out_vld | output | 1 | High for one cycle when a new cos/sin pair is presented |

## Verification
On every cycle the assertions check four things: each phase change is one of the two legal steps, the phase holds on idle cycles, the strobe loads and holds the current bit, and `out_vld` follows the sample enable after two edges. They also check that the output magnitude stays inside the constant-envelope band and that the outputs hold between samples. Other behaviours need the bench's own reference, which is built from ideal trigonometry and phase arithmetic. These are the exact quarter-turn swing per symbol, the exact sample values for each quadrant, and the ordering when a strobe coincides with an enabled sample. The bench also exercises bursts with idle gaps between samples.

// File: rtl/msk_pkg.sv
package msk_pkg;

  // Quarter-wave folding: which way to read the table and whether to negate
  typedef struct packed {
    logic mirror;
    logic negate;
  } fold_t;

  // Quadrant 0..3 counter-clockwise; cosine uses quadrant + 1
  function automatic fold_t sin_fold(input logic [1:0] quad);
    fold_t f;
    f.mirror = quad[0];
    f.negate = quad[1];
    return f;
  endfunction

endpackage

// File: rtl/msk_sym_ctrl.sv
module msk_sym_ctrl #(
  parameter int PW = 16,
  parameter logic [PW-1:0] STEP_UP = '0,
  parameter logic [PW-1:0] STEP_DN = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_stb,
  input  logic          sym_bit,
  output logic          cur_bit,
  output logic [PW-1:0] step
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_bit <= 1'b0;
    else if (sym_stb) cur_bit <= sym_bit;
  end

  assign step = cur_bit ? STEP_UP : STEP_DN;

  // R3
  bit_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |=> (cur_bit == $past(sym_bit)));

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_stb |=> $stable(cur_bit));

endmodule

// File: rtl/msk_phase_acc.sv
module msk_phase_acc #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_en,
  input  logic [PW-1:0] step,
  output logic [PW-1:0] phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (adv_en) phase <= phase + step;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(phase));

endmodule

// File: rtl/msk_sincos_lut.sv
module msk_sincos_lut import msk_pkg::*; #(
  parameter int QA = 6,
  parameter int OW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_en,
  input  logic [QA+1:0]        addr,
  output logic signed [OW-1:0] cos_o,
  output logic signed [OW-1:0] sin_o,
  output logic                 vld
);

  localparam int  QN    = 1 << QA;
  localparam int  AMP   = (1 << (OW-1)) - 1;
  localparam int  AMP_LO = AMP*AMP - 2*AMP - 2;
  localparam int  AMP_HI = AMP*AMP + 2*AMP + 2;
  localparam real HALF_PI = 1.5707963267948966;

  // Magnitude table sampled at bucket centres, so a mirrored read is ~idx
  logic [OW-2:0] rom [QN];
  for (genvar i = 0; i < QN; i++) begin : g_rom
    localparam real ANG = (real'(i) + 0.5) * HALF_PI / real'(QN);
    assign rom[i] = (OW-1)'($rtoi(real'(AMP) * $sin(ANG) + 0.5));
  end

  logic [1:0]    quad;
  logic [QA-1:0] idx;
  assign quad = addr[QA+1:QA];
  assign idx  = addr[QA-1:0];

  fold_t fs, fc;
  logic [OW-2:0] mag_s, mag_c;
  logic signed [OW-1:0] pos_s, pos_c, s_val, c_val;

  always_comb begin
    fs    = sin_fold(quad);
    fc    = sin_fold(quad + 2'd1);
    mag_s = rom[fs.mirror ? ~idx : idx];
    mag_c = rom[fc.mirror ? ~idx : idx];
    pos_s = $signed({1'b0, mag_s});
    pos_c = $signed({1'b0, mag_c});
    s_val = fs.negate ? -pos_s : pos_s;
    c_val = fc.negate ? -pos_c : pos_c;
  end

  logic en_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      vld   <= 1'b0;
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      en_d <= lk_en;
      vld  <= en_d;
      if (en_d) begin
        cos_o <= c_val;
        sin_o <= s_val;
      end
    end
  end

  int amp_sq;
  assign amp_sq = int'(cos_o) * int'(cos_o) + int'(sin_o) * int'(sin_o);

  // R9
  amp_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (amp_sq >= AMP_LO && amp_sq <= AMP_HI));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_d |=> ($stable(cos_o) && $stable(sin_o)));

endmodule

// File: rtl/msk_phase_mod.sv
module msk_phase_mod #(
  parameter int PW       = 16,
  parameter int SYM_LEN  = 16,
  parameter int CARR_INC = 2048,
  parameter int QA       = 6,
  parameter int OW       = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en,
  input  logic                 sym_stb,
  input  logic                 sym_bit,
  output logic [PW-1:0]        phase_o,
  output logic signed [OW-1:0] cos_o,
  output logic signed [OW-1:0] sin_o,
  output logic                 out_vld
);

  localparam int QTURN   = 1 << (PW-2);
  localparam int DEV_INC = QTURN / SYM_LEN;
  localparam logic [PW-1:0] STEP_UP = PW'(CARR_INC + DEV_INC);
  localparam logic [PW-1:0] STEP_DN = PW'(CARR_INC - DEV_INC);

  logic          cur_bit;
  logic [PW-1:0] step;

  msk_sym_ctrl #(.PW(PW), .STEP_UP(STEP_UP), .STEP_DN(STEP_DN)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym_stb (sym_stb),
    .sym_bit (sym_bit),
    .cur_bit (cur_bit),
    .step    (step)
  );

  msk_phase_acc #(.PW(PW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (smp_en),
    .step   (step),
    .phase  (phase_o)
  );

  msk_sincos_lut #(.QA(QA), .OW(OW)) u_lut (
    .clk   (clk),
    .rst_n (rst_n),
    .lk_en (smp_en),
    .addr  (phase_o[PW-1 -: QA+2]),
    .cos_o (cos_o),
    .sin_o (sin_o),
    .vld   (out_vld)
  );

  // R2 R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> ((PW'(phase_o - $past(phase_o)) == STEP_UP) ||
                (PW'(phase_o - $past(phase_o)) == STEP_DN)));

  // R7
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> ##1 out_vld);

  // R7
  vld_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ##1 !out_vld);

endmodule

// File: tb/msk_phase_mod_bench.sv
`timescale 1ns/1ps
module msk_phase_mod_bench;

  localparam int PW = 16, N = 16, CARR = 2048, QA = 6, OW = 12;
  localparam int MASK = (1 << PW) - 1;
  localparam int QT   = 1 << (PW-2);
  localparam int DEV  = QT / N;
  localparam int UP   = (CARR + DEV) & MASK;
  localparam int DN   = (CARR - DEV) & MASK;
  localparam int AMP  = (1 << (OW-1)) - 1;
  localparam real PI  = 3.14159265358979;

  logic clk = 0, rst_n = 0, smp_en = 0, sym_stb = 0, sym_bit = 0;
  logic [PW-1:0] phase_o;
  logic signed [OW-1:0] cos_o, sin_o;
  logic out_vld;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msk_phase_mod #(.PW(PW), .SYM_LEN(N), .CARR_INC(CARR), .QA(QA), .OW(OW)) u_msk_phase_mod (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sym_stb(sym_stb), .sym_bit(sym_bit),
    .phase_o(phase_o), .cos_o(cos_o), .sin_o(sin_o), .out_vld(out_vld));

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  function automatic int ideal(input int ph, input bit want_cos);
    int b, mag;
    real ang, v;
    b   = ph >> (PW-QA-2);
    ang = (real'(b) + 0.5) * 2.0 * PI / real'(1 << (QA+2));
    v   = (want_cos ? $cos(ang) : $sin(ang)) * real'(AMP);
    mag = $rtoi((v < 0.0 ? -v : v) + 0.5);
    return (v < 0.0) ? -mag : mag;
  endfunction

  // Behavioural reference, advanced on every clock edge
  int m_ph = 0, m_c = 0, m_s = 0, last_ph = 0;
  bit m_bit = 0, m_en1 = 0, m_vld = 0, m_adv = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_bit = 0; m_en1 = 0; m_vld = 0; m_c = 0; m_s = 0; m_adv = 0;
    end else begin
      if (m_en1) begin
        m_c = ideal(m_ph, 1'b1);
        m_s = ideal(m_ph, 1'b0);
      end
      m_vld = m_en1;
      m_en1 = smp_en;
      m_adv = smp_en;
      if (smp_en) m_ph = (m_ph + (m_bit ? CARR + DEV : CARR - DEV)) & MASK;
      if (sym_stb) m_bit = sym_bit;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int d, sq, ca, sa;
      ca = int'(cos_o);
      sa = int'(sin_o);
      check(int'(phase_o) == m_ph, "R2 R3 phase", int'(phase_o), m_ph);
      check(out_vld == m_vld, "R7 out_vld", int'(out_vld), int'(m_vld));
      if (m_vld) begin
        check((ca - m_c) <= 1 && (m_c - ca) <= 1, "R8 cos", ca, m_c);
        check((sa - m_s) <= 1 && (m_s - sa) <= 1, "R8 sin", sa, m_s);
        sq = ca*ca + sa*sa;
        check(sq >= AMP*AMP - 2*AMP - 2 && sq <= AMP*AMP + 2*AMP + 2, "R9 envelope", sq, AMP*AMP);
      end else begin
        check((ca - m_c) <= 1 && (m_c - ca) <= 1, "R10 cos hold", ca, m_c);
        check((sa - m_s) <= 1 && (m_s - sa) <= 1, "R10 sin hold", sa, m_s);
      end
      if (m_adv) begin
        d = (int'(phase_o) - last_ph) & MASK;
        check(d == UP || d == DN, "R4 continuity", d, UP);
      end else begin
        check(int'(phase_o) == last_ph, "R2 idle hold", int'(phase_o), last_ph);
      end
      last_ph = int'(phase_o);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // One symbol: strobe (optionally with an enabled sample), then N samples
  task automatic send_sym(input bit b, input bit ovl, input bit gaps);
    int start, d, exp_d;
    smp_en = ovl; sym_stb = 1; sym_bit = b;
    tick();
    sym_stb = 0; smp_en = 0;
    start = int'(phase_o);
    for (int k = 0; k < N; k++) begin
      if (gaps && (k % 3 == 1)) begin
        smp_en = 0;
        tick();
      end
      smp_en = 1;
      tick();
    end
    smp_en = 0;
    d     = (int'(phase_o) - start) & MASK;
    exp_d = (CARR*N + (b ? QT : -QT)) & MASK;
    check(d == exp_d, b ? "R5 R6 symbol swing bit1" : "R5 R6 symbol swing bit0", d, exp_d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(phase_o == '0, "R1 phase", int'(phase_o), 0);
    check(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
    check(cos_o == '0 && sin_o == '0, "R1 cos/sin", int'(cos_o), 0);
    @(posedge clk); #2;
    rst_n = 1;
    tick();
    // R1: current bit is 0 before any strobe
    smp_en = 1;
    tick();
    smp_en = 0;
    check(int'(phase_o) == DN, "R1 initial bit 0 step", int'(phase_o), DN);
    repeat (3) tick();

    for (int i = 0; i < 4; i++) send_sym(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) send_sym(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) send_sym(i[0], 1'b1, 1'b0);   // R3 overlap
    begin
      bit pat [7] = '{1, 1, 0, 1, 0, 0, 1};
      foreach (pat[i]) send_sym(pat[i], i[0], 1'b1);
    end
    repeat (6) tick();   // R10 idle hold
    for (int i = 0; i < 40; i++) send_sym(((i * 5) % 7) > 3, i[1], i[2]);
    repeat (4) tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule